// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table that sits in a synchronous memory with a one-cycle read latency. A request carries the virtual address and the table number of the requesting process's root table. The request is accepted over a valid/ready handshake. The walker then reads one entry from the root table. That entry either names a second-level table or is marked absent. When it names a table, the walker reads one entry from that table. The result comes back as a physical address and a fault flag, and it is held until the consumer takes it.

The virtual address splits into three fields. Bits 31:22 index the root table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset inside a 4096-byte page.

Every table entry is 16 bits wide. Bit 15 is the present flag and bits 14:0 carry a number. A table holds 1024 entries and so spans 2048 bytes. The byte address of an entry is therefore {table number, index, 1'b0}. The physical address is {frame number, offset}, which is 27 bits wide. No arithmetic beyond bit concatenation is used.

Top module: `ptw_two_level`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. It drops in the cycle after a request is accepted (`req_valid && req_ready` at a clock edge). It returns high only in the cycle after the response handshake.
- R2: In the cycle after acceptance, the walker drives `mem_rd_en` high with `mem_addr` = {`req_root`, vaddr[31:22], 1'b0}, that is, root*2048 + index*2.
- R3: If the root-table entry has bit 15 clear, the response carries `rsp_fault`=1 and no second read is issued.
- R4: If the root-table entry has bit 15 set, exactly one more read is issued, at {entry[14:0], vaddr[21:12], 1'b0}.
- R5: If the second-level entry has bit 15 set, the response has `rsp_fault`=0 and `rsp_paddr` = {entry[14:0], vaddr[11:0]}.
- R6: If the second-level entry has bit 15 clear, the response has `rsp_fault`=1. In that case `rsp_paddr` carries no meaning.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values. In the cycle after the handshake, `rsp_valid` is low.
- R8: Synchronous active-low reset leaves `req_ready`=1, `rsp_valid`=0 and `mem_rd_en`=0. A reset asserted during a walk abandons that walk.
- R9: `mem_rd_en` is never high in two consecutive cycles. Each entry is taken from `mem_rdata` in the cycle after its read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 15 | Table number of the process root table |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 27 | Physical address {frame, offset} |
| rsp_fault | output | 1 | Translation failed at either level |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_addr | output | 26 | Byte address of the entry being read |
| mem_rdata | input | 16 | Entry data, valid the cycle after the read |

## Verification
Two things can happen in the same cycle: a finished response waits for its handshake while a new request is already offered. The bench provokes this by keeping `req_valid` high with a second address while it stalls `rsp_ready` for several cycles. It checks that `req_ready` stays low and that the first result stays frozen throughout the stall. It then checks that the waiting request is taken only in the cycle after the handshake, and that the second walk translates its own address from reads at the addresses it should use.

// File: rtl/ptw_pkg.sv
// ptw_pkg: shared geometry defaults and walk state encoding for the
// two-level page table walker. Assumes byte addressing of table memory.
package ptw_pkg;
    localparam int DEF_OFF_W = 12;   // page offset bits (4096-byte pages)
    localparam int DEF_IDX_W = 10;   // index bits per table level
    localparam int DEF_PTE_W = 16;   // entry width, top bit = present

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_WT2  = 3'd4,
        ST_RSP  = 3'd5
    } walk_state_t;
endpackage

// File: rtl/ptw_vaddr_split.sv
// ptw_vaddr_split: cuts a virtual address into root index, leaf index and
// page offset. Assumes the address is exactly 2*IDX_W+OFF_W bits wide.
module ptw_vaddr_split #(
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    localparam int VA_W = 2 * IDX_W + OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] idx_root,
    output logic [IDX_W-1:0] idx_leaf,
    output logic [OFF_W-1:0] offset
);
    // Field extraction by wiring only.
    always_comb begin
        idx_root = vaddr[VA_W-1 -: IDX_W];
        idx_leaf = vaddr[OFF_W + IDX_W - 1 -: IDX_W];
        offset   = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_entry_addr.sv
// ptw_entry_addr: byte address of one table entry. A table spans
// 2^IDX_W entries of two bytes, so base = tnum << (IDX_W+1) and the
// entry sits at base + idx*2; both collapse to a concatenation.
// Assumes 16-bit entries (two bytes each).
module ptw_entry_addr #(
    parameter int IDX_W  = 10,
    parameter int TNUM_W = 15,
    localparam int MA_W  = TNUM_W + IDX_W + 1
) (
    input  logic [TNUM_W-1:0] tnum,
    input  logic [IDX_W-1:0]  idx,
    output logic [MA_W-1:0]   byte_addr
);
    // Concatenate table number, index and the zero byte-select bit.
    always_comb byte_addr = {tnum, idx, 1'b0};
endmodule

// File: rtl/ptw_pte_decode.sv
// ptw_pte_decode: splits a table entry into present flag and number.
// Assumes the present flag is the most significant entry bit.
module ptw_pte_decode #(
    parameter int PTE_W = 16,
    localparam int NUM_W = PTE_W - 1
) (
    input  logic [PTE_W-1:0] pte,
    output logic             present,
    output logic [NUM_W-1:0] num
);
    // Flag and payload extraction.
    always_comb begin
        present = pte[PTE_W-1];
        num     = pte[NUM_W-1:0];
    end
endmodule

// File: rtl/ptw_walk_ctrl.sv
// ptw_walk_ctrl: sequencing of the walk. One read per level, each read
// followed by a wait cycle in which the returned entry is consumed.
// Assumes memory data is valid exactly one cycle after the read strobe.
module ptw_walk_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_ready,
    input  logic pte_present,
    output logic accept,
    output logic rd_en,
    output logic rd_leaf,
    output logic cap_root,
    output logic cap_leaf,
    output logic idle,
    output logic rsp_valid
);
    walk_state_t state_q, state_d;

    // Next-state selection for the walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RD1;
            ST_RD1:  state_d = ST_WT1;
            ST_WT1:  state_d = pte_present ? ST_RD2 : ST_RSP;
            ST_RD2:  state_d = ST_WT2;
            ST_WT2:  state_d = ST_RSP;
            ST_RSP:  if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the current state.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        accept    = idle && req_valid;
        rd_en     = (state_q == ST_RD1) || (state_q == ST_RD2);
        rd_leaf   = (state_q == ST_RD2);
        cap_root  = (state_q == ST_WT1);
        cap_leaf  = (state_q == ST_WT2);
        rsp_valid = (state_q == ST_RSP);
    end
endmodule

// File: rtl/ptw_two_level.sv
// ptw_two_level: two-level page table walker. Accepts a virtual address
// and root table number, reads the root entry, then (if present) the
// leaf entry, and returns {frame, offset} with a fault flag.
// Assumes a synchronous table memory with one-cycle read latency and
// byte addressing; the response is held until rsp_ready.
module ptw_two_level
    import ptw_pkg::*;
#(
    parameter int OFF_W = DEF_OFF_W,
    parameter int IDX_W = DEF_IDX_W,
    parameter int PTE_W = DEF_PTE_W,
    localparam int VA_W   = 2 * IDX_W + OFF_W,
    localparam int TNUM_W = PTE_W - 1,
    localparam int MA_W   = TNUM_W + IDX_W + 1,
    localparam int PA_W   = TNUM_W + OFF_W,
    localparam int LEVELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [TNUM_W-1:0] req_root,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_rd_en,
    output logic [MA_W-1:0]   mem_addr,
    input  logic [PTE_W-1:0]  mem_rdata
);
    logic [VA_W-1:0]   vaddr_q;
    logic [TNUM_W-1:0] root_q, leaf_tbl_q, frame_q;
    logic              fault_q;

    logic              accept, rd_leaf, cap_root, cap_leaf, idle;
    logic              pte_present;
    logic [TNUM_W-1:0] pte_num;
    logic [IDX_W-1:0]  idx_root, idx_leaf;
    logic [OFF_W-1:0]  offset;

    logic [TNUM_W-1:0] lvl_tnum [LEVELS];
    logic [IDX_W-1:0]  lvl_idx  [LEVELS];
    logic [MA_W-1:0]   lvl_addr [LEVELS];

    ptw_walk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .rsp_ready   (rsp_ready),
        .pte_present (pte_present),
        .accept      (accept),
        .rd_en       (mem_rd_en),
        .rd_leaf     (rd_leaf),
        .cap_root    (cap_root),
        .cap_leaf    (cap_leaf),
        .idle        (idle),
        .rsp_valid   (rsp_valid)
    );

    ptw_vaddr_split #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .vaddr    (vaddr_q),
        .idx_root (idx_root),
        .idx_leaf (idx_leaf),
        .offset   (offset)
    );

    ptw_pte_decode #(.PTE_W(PTE_W)) u_decode (
        .pte     (mem_rdata),
        .present (pte_present),
        .num     (pte_num)
    );

    // Per-level table number and index feeding the address generators.
    always_comb begin
        lvl_tnum[0] = root_q;
        lvl_idx[0]  = idx_root;
        lvl_tnum[1] = leaf_tbl_q;
        lvl_idx[1]  = idx_leaf;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        ptw_entry_addr #(.IDX_W(IDX_W), .TNUM_W(TNUM_W)) u_addr (
            .tnum      (lvl_tnum[g]),
            .idx       (lvl_idx[g]),
            .byte_addr (lvl_addr[g])
        );
    end

    // Select the entry address of the level being read.
    always_comb mem_addr = rd_leaf ? lvl_addr[1] : lvl_addr[0];

    // Request capture and per-level result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q    <= '0;
            root_q     <= '0;
            leaf_tbl_q <= '0;
            frame_q    <= '0;
            fault_q    <= 1'b0;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                root_q  <= req_root;
                fault_q <= 1'b0;
            end
            if (cap_root) begin
                leaf_tbl_q <= pte_num;
                if (!pte_present) begin
                    fault_q <= 1'b1;
                    frame_q <= '0;
                end
            end
            if (cap_leaf) begin
                frame_q <= pte_num;
                fault_q <= !pte_present;
            end
        end
    end

    // Handshake and result outputs.
    always_comb begin
        req_ready = idle;
        rsp_paddr = {frame_q, offset};
        rsp_fault = fault_q;
    end
endmodule

// File: rtl/ptw_checker.sv
// ptw_checker: temporal properties of the walker's ports, bound to
// ptw_two_level. Observes only, drives nothing.
module ptw_checker #(
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PTE_W = 16,
    localparam int VA_W   = 2 * IDX_W + OFF_W,
    localparam int TNUM_W = PTE_W - 1,
    localparam int MA_W   = TNUM_W + IDX_W + 1,
    localparam int PA_W   = TNUM_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [TNUM_W-1:0] req_root,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_fault,
    input logic              mem_rd_en,
    input logic [MA_W-1:0]   mem_addr
);
    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    root_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en &&
            mem_addr == {$past(req_root), $past(req_vaddr[VA_W-1 -: IDX_W]), 1'b0}));

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R7
    rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_valid);

    // R9
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R1
    ready_vs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !mem_rd_en));
endmodule

bind ptw_two_level ptw_checker #(.OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_root  (req_root),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr)
);

// File: tb/ptw_two_level_bench.sv
// Bench for ptw_two_level. Table memory is modelled by a function:
// tables 0..7 are root tables whose entry i is present unless i[1:0]==3
// and names leaf table 16+i; any other table's entry i is present unless
// i[2:0]==7 and holds frame (table ^ i).
module ptw_two_level_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [14:0] req_root = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [26:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_en;
    logic [25:0] mem_addr;
    logic [15:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int rd_cnt = 0;
    logic [25:0] rd_log [4];

    always #10 clk = ~clk;

    ptw_two_level u_ptw_two_level (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] pte_at(input logic [25:0] a);
        logic [14:0] tn;
        logic [9:0]  ix;
        tn = a[25:11];
        ix = a[10:1];
        if (tn < 15'd8) return {(ix[1:0] != 2'b11), 15'(16 + ix)};
        else            return {(ix[2:0] != 3'b111), tn ^ {5'b0, ix}};
    endfunction

    // One-cycle-latency memory model and read logger.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= pte_at(mem_addr);
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [14:0] root;
        logic [31:0] va;
        logic        flt;
        logic [26:0] pa;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{15'd1, 32'h0040_1ABC, 1'b0, 27'h0010ABC},  // full walk
        '{15'd2, 32'h00C0_0123, 1'b1, 27'h0},        // root entry absent
        '{15'd3, 32'h0080_7FFF, 1'b1, 27'h0},        // leaf entry absent
        '{15'd4, 32'hFF7F_E456, 1'b0, 27'h07F3456},  // high indices
        '{15'd5, 32'h0000_0000, 1'b0, 27'h0010000}   // all-zero address
    };

    // Wait for a response, then judge its fields and the reads made.
    task automatic judge(input logic [14:0] root, input logic [31:0] va,
                         input logic flt, input logic [26:0] pa);
        logic [9:0] i1;
        int n;
        i1 = va[31:22];
        n = 0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R5", "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rsp_fault == flt, flt ? "R3/R6" : "R5", "fault",
              32'(rsp_fault), 32'(flt));
        if (!flt) check(rsp_paddr == pa, "R5", "paddr", 32'(rsp_paddr), 32'(pa));
        check(rd_log[0] == {root, i1, 1'b0}, "R2", "root read addr",
              32'(rd_log[0]), 32'({root, i1, 1'b0}));
        if (i1[1:0] == 2'b11) begin
            check(rd_cnt == 1, "R3", "read count", 32'(rd_cnt), 32'd1);
        end else begin
            check(rd_cnt == 2, "R4", "read count", 32'(rd_cnt), 32'd2);
            check(rd_log[1] == {15'(16 + i1), va[21:12], 1'b0}, "R4", "leaf read addr",
                  32'(rd_log[1]), 32'({15'(16 + i1), va[21:12], 1'b0}));
        end
    endtask

    task automatic walk(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_root  = v.root;
        rd_cnt    = 0;
        check(req_ready, "R1", "ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1", "ready while busy", 32'(req_ready), 32'd0);
        judge(v.root, v.va, v.flt, v.pa);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R7", "idle after handshake",
              32'({rsp_valid, req_ready}), 32'b01);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [26:0] held_pa;
        logic        held_f;
        int n;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(req_ready && !rsp_valid && !mem_rd_en, "R8", "reset outputs",
              32'({req_ready, rsp_valid, mem_rd_en}), 32'b100);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) walk(VECS[k]);

        // R7 / R1 stalled response with a new request already waiting.
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1;
        req_vaddr = VECS[0].va;
        req_root  = VECS[0].root;
        rd_cnt    = 0;
        @(negedge clk);
        req_vaddr = VECS[3].va;
        req_root  = VECS[3].root;
        n = 0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        held_pa = rsp_paddr;
        held_f  = rsp_fault;
        check(held_pa == VECS[0].pa && !held_f, "R5", "paddr before stall",
              32'(held_pa), 32'(VECS[0].pa));
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == held_pa && rsp_fault == held_f,
                  "R7", "held response", 32'(rsp_paddr), 32'(held_pa));
            check(!req_ready, "R1", "no accept while responding",
                  32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R7", "drop after handshake",
              32'({rsp_valid, req_ready}), 32'b01);
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1", "waiting request taken", 32'(req_ready), 32'd0);
        judge(VECS[3].root, VECS[3].va, VECS[3].flt, VECS[3].pa);
        @(negedge clk);

        // R9 reads spaced apart during a full walk.
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VECS[4].va;
        req_root  = VECS[4].root;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            logic prev_rd;
            logic bad;
            prev_rd = 1'b0;
            bad = 1'b0;
            for (int c = 0; c < 6; c++) begin
                if (prev_rd && mem_rd_en) bad = 1'b1;
                prev_rd = mem_rd_en;
                @(negedge clk);
            end
            check(!bad, "R9", "back-to-back reads", 32'(bad), 32'd0);
        end
        @(negedge clk);

        // R8 reset during a walk.
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VECS[0].va;
        req_root  = VECS[0].root;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready && !rsp_valid && !mem_rd_en, "R8", "walk abandoned",
              32'({req_ready, rsp_valid, mem_rd_en}), 32'b100);
        repeat (8) @(negedge clk);
        check(!rsp_valid, "R8", "no late response", 32'(rsp_valid), 32'd0);

        walk(VECS[2]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule